// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers up to 32 interrupt sources into one register bank. Software reaches the bank through a small word-addressed register port, and a single level interrupt line comes out of it. A one-cycle pulse on a source input sets a sticky cause bit. A mask bit per source decides whether that cause can reach the interrupt line. A configuration word picks, bit by bit, how software acknowledges each cause. One choice is to write a one to the bit. The other is to read the bit, in which case the read clears it.

Besides the plain cause and mask words, the bank has several other views. A masked view shows only the causes that can raise the interrupt. A write-only set word lets software inject causes. Two write-only aliases set or clear mask bits without a read-modify-write. The same bit index names the same source in every word. The interrupt output is a flop, so it never glitches.

Top module: `irq_bank_top`

## Requirements
- R1: After reset the cause word is 0, the acknowledge-mode word is 0 (every source write-one-to-clear), the mask is all ones, and irqOut is 0.
- R2: Word offsets are 0 mode, 1 cause, 2 masked cause, 3 cause set, 4 mask, 5 mask set, 6 mask clear, and offset 7 is unused. Reads are combinational while regRd is high, and regRdata is 0 while regRd is low.
- R3: A high srcEvent bit sets the cause bit with the same index at the next clock edge. The bit then stays set until software acknowledges it.
- R4: A write to offset 1 clears each cause bit whose data bit is 1 and whose mode bit is 0. Data bits that are 0, and bits whose mode is 1, are left unchanged.
- R5: A read of offset 1 returns the cause value as it was before the read. At that edge it clears only the cause bits whose mode bit is 1.
- R6: Offset 2 reads as cause AND NOT mask. Writing to it clears cause bits by the R4 rule. Reading it clears, by the R5 rule, only the bits that the read returned.
- R7: Writing offset 3 sets each cause bit whose data bit is 1. Zero bits have no effect.
- R8: Offset 4 is read/write. Writing offset 5 sets the mask bits whose data bit is 1. Writing offset 6 clears the mask bits whose data bit is 1. Zero bits leave the mask unchanged.
- R9: When a source event or a set write meets a clear of the same bit in the same cycle, the bit ends up set.
- R10: irqOut at one edge equals the OR of (cause AND NOT mask) as held just before that edge.
- R11: Offsets 3, 5, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Word offset |
| regWr | input | 1 | Write strobe, one access per cycle |
| regRd | input | 1 | Read strobe; clear-on-read acts at the edge |
| regWdata | input | NUM_SRC | Write data |
| regRdata | output | NUM_SRC | Read data, combinational |
| srcEvent | input | NUM_SRC | Per-source event pulses |
| irqOut | output | 1 | Registered level interrupt |

## Verification
The properties assume that a read or a write lasts exactly one cycle. The acknowledge checks also assume that no source event fires in the cycle they examine, because an event in that cycle would legally re-set the bit. The bench drives every access for one cycle on the falling edge. It keeps srcEvent at zero except in the cycles where it deliberately tests a collision. It never asserts regRd and regWr together.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_MODE   = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_MASKED = 3'd2,
    SEL_SET    = 3'd3,
    SEL_MASK   = 3'd4,
    SEL_MSET   = 3'd5,
    SEL_MCLR   = 3'd6,
    SEL_SPARE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrMode;
    logic    ackCause;
    logic    setCause;
    logic    wrMask;
    logic    setMask;
    logic    clrMask;
    logic    rdCause;
    logic    rdMasked;
    logic    rdEn;
    regSel_e rdSel;
  } bankStrobe_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  output bankStrobe_t           strobe
);

  regSel_e sel;

  always_comb begin
    sel          = regSel_e'(regAddr);
    strobe       = '0;
    strobe.rdEn  = regRd;
    strobe.rdSel = sel;
    if (regWr) begin
      unique case (sel)
        SEL_MODE:   strobe.wrMode   = 1'b1;
        SEL_CAUSE,
        SEL_MASKED: strobe.ackCause = 1'b1;
        SEL_SET:    strobe.setCause = 1'b1;
        SEL_MASK:   strobe.wrMask   = 1'b1;
        SEL_MSET:   strobe.setMask  = 1'b1;
        SEL_MCLR:   strobe.clrMask  = 1'b1;
        default:    ;
      endcase
    end
    if (regRd) begin
      strobe.rdCause  = (sel == SEL_CAUSE);
      strobe.rdMasked = (sel == SEL_MASKED);
    end
  end

endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] srcEvent,
  output logic [NUM_SRC-1:0] rdata,
  output logic [NUM_SRC-1:0] causeQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] modeQ,
  output logic               irqQ
);

  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] pendView;

  assign pendView = causeQ & ~maskQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic setBit;
    logic clrBit;
    assign setBit = srcEvent[i] | (strobe.setCause & wdata[i]);
    assign clrBit = (strobe.ackCause & wdata[i] & ~modeQ[i])
                  | (strobe.rdCause  & modeQ[i])
                  | (strobe.rdMasked & modeQ[i] & ~maskQ[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       causeQ[i] <= 1'b0;
      else if (setBit) causeQ[i] <= 1'b1;
      else if (clrBit) causeQ[i] <= 1'b0;
    end
  end

  always_comb begin
    maskNext = maskQ;
    if (strobe.wrMask)  maskNext = wdata;
    if (strobe.setMask) maskNext = maskQ | wdata;
    if (strobe.clrMask) maskNext = maskQ & ~wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      modeQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      maskQ <= maskNext;
      if (strobe.wrMode) modeQ <= wdata;
      irqQ <= |pendView;
    end
  end

  always_comb begin
    rdata = '0;
    if (strobe.rdEn) begin
      unique case (strobe.rdSel)
        SEL_MODE:   rdata = modeQ;
        SEL_CAUSE:  rdata = causeQ;
        SEL_MASKED: rdata = pendView;
        SEL_MASK:   rdata = maskQ;
        default:    rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [NUM_SRC-1:0]    regWdata,
  output logic [NUM_SRC-1:0]    regRdata,
  input  logic [NUM_SRC-1:0]    srcEvent,
  output logic                  irqOut
);

  bankStrobe_t        strobe;
  logic [NUM_SRC-1:0] causeQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] modeQ;

  irq_bank_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWr   (regWr),
    .regRd   (regRd),
    .strobe  (strobe)
  );

  irq_bank_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (regWdata),
    .srcEvent (srcEvent),
    .rdata    (regRdata),
    .causeQ   (causeQ),
    .maskQ    (maskQ),
    .modeQ    (modeQ),
    .irqQ     (irqOut)
  );

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         regAddr,
  input logic               regWr,
  input logic               regRd,
  input logic [NUM_SRC-1:0] regWdata,
  input logic [NUM_SRC-1:0] regRdata,
  input logic [NUM_SRC-1:0] srcEvent,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] causeQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] modeQ
);

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (|srcEvent) |=> ((causeQ & $past(srcEvent)) == $past(srcEvent))); // R3

  AST_W1C_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd1 && srcEvent == '0)
      |=> ((causeQ & $past(regWdata & ~modeQ)) == '0)); // R4

  AST_COR_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !regWr && regAddr == 3'd1 && srcEvent == '0)
      |=> ((causeQ & $past(modeQ)) == '0)); // R5

  AST_MASKED_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 3'd2) |-> (regRdata == (causeQ & ~maskQ))); // R6

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd5)
      |=> ((maskQ & $past(regWdata)) == $past(regWdata))); // R8

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(causeQ & ~maskQ)))); // R10

  AST_WO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && (regAddr == 3'd3 || regAddr == 3'd5 || regAddr == 3'd6 || regAddr == 3'd7))
      |-> (regRdata == '0)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!regRd) |-> (regRdata == '0)); // R2

endmodule

bind irq_bank_top irq_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWr    (regWr),
  .regRd    (regRd),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .srcEvent (srcEvent),
  .irqOut   (irqOut),
  .causeQ   (causeQ),
  .maskQ    (maskQ),
  .modeQ    (modeQ)
);

// File: tb/irq_bank_top_bench.sv
module irq_bank_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    regAddr = '0;
  logic          regWr = 1'b0;
  logic          regRd = 1'b0;
  logic [NS-1:0] regWdata = '0;
  logic [NS-1:0] regRdata;
  logic [NS-1:0] srcEvent = '0;
  logic          irqOut;

  int total = 0;
  int bad = 0;
  logic [NS-1:0] mCause = '0;
  logic [NS-1:0] mMask = '1;
  logic [NS-1:0] mMode = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_bank_top #(.NUM_SRC(NS)) u_irq_bank_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .srcEvent(srcEvent), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [NS-1:0] got, input logic [NS-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [NS-1:0] viewOf(input logic [2:0] a);
    case (a)
      3'd0: return mMode;
      3'd1: return mCause;
      3'd2: return mCause & ~mMask;
      3'd4: return mMask;
      default: return '0;
    endcase
  endfunction

  // one bus cycle: drive on falling edge, check read before the edge, model after it
  task automatic op(input logic wr, input logic rd, input logic [2:0] a,
                    input logic [NS-1:0] d, input logic [NS-1:0] ev, input string tag);
    logic [NS-1:0] clr;
    logic [NS-1:0] setv;
    @(negedge clk);
    regWr = wr; regRd = rd; regAddr = a; regWdata = d; srcEvent = ev;
    #1;
    if (rd) chk(tag, regRdata, viewOf(a));
    clr = '0;
    if (rd && a == 3'd1) clr = mCause & mMode;
    if (rd && a == 3'd2) clr = mCause & ~mMask & mMode;
    if (wr && (a == 3'd1 || a == 3'd2)) clr |= d & ~mMode;
    setv = ev | ((wr && a == 3'd3) ? d : '0);
    @(posedge clk);
    mCause = (mCause & ~clr) | setv;
    if (wr && a == 3'd0) mMode = d;
    if (wr && a == 3'd4) mMask = d;
    if (wr && a == 3'd5) mMask = mMask | d;
    if (wr && a == 3'd6) mMask = mMask & ~d;
    #1;
    regWr = 0; regRd = 0; regWdata = '0; srcEvent = '0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    op(1'b0, 1'b1, a, '0, '0, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NS-1:0] d);
    op(1'b1, 1'b0, a, d, '0, "wr");
  endtask

  task automatic idleIrq(input string tag);
    @(posedge clk);
    #2;
    chk(tag, {{(NS-1){1'b0}}, irqOut}, {{(NS-1){1'b0}}, |(mCause & ~mMask)});
    chk("R2 idle rdata", regRdata, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1 reset state
    chk("R1 irq", {{(NS-1){1'b0}}, irqOut}, '0);
    rd(3'd0, "R1 mode");
    rd(3'd1, "R1 cause");
    rd(3'd4, "R1 mask");

    // R3 R4: per-source capture and write-one-to-clear, all sources masked
    for (int i = 0; i < NS; i++) begin
      op(1'b0, 1'b0, 3'd0, '0, NS'(1) << i, "R3 ev");
      rd(3'd1, "R3 captured");
      rd(3'd2, "R6 masked hides");
      wr(3'd1, ~(NS'(1) << i) & 32'h5555_aaaa);
      rd(3'd1, "R4 zero bits keep");
      wr(3'd1, NS'(1) << i);
      rd(3'd1, "R4 cleared");
      idleIrq("R10 masked");
    end

    // R8 mask aliases and R10 interrupt
    wr(3'd6, 32'hffff_ffff);
    rd(3'd4, "R8 mask clear alias");
    wr(3'd5, 32'h0000_0f00);
    rd(3'd4, "R8 mask set alias");
    op(1'b0, 1'b0, 3'd0, '0, 32'h0000_0020, "R3 ev");
    idleIrq("R10 raised");
    rd(3'd2, "R6 masked view");
    wr(3'd2, 32'h0000_0020);
    rd(3'd1, "R6 write clears");
    idleIrq("R10 dropped");
    op(1'b0, 1'b0, 3'd0, '0, 32'h0000_0100, "R3 ev");
    idleIrq("R10 masked source");

    // R5 R7 clear-on-read on the low half
    wr(3'd0, 32'h0000_ffff);
    rd(3'd0, "R5 mode rw");
    wr(3'd3, 32'h00ff_00ff);
    rd(3'd1, "R7 set then R5 read");
    rd(3'd1, "R5 only COR bits cleared");
    wr(3'd3, 32'h0000_0000);
    rd(3'd1, "R7 zero no effect");
    wr(3'd3, 32'h0000_0003);
    wr(3'd1, 32'h0000_0003);
    rd(3'd1, "R4 COR bits ignore write");

    // R6 masked clear-on-read
    wr(3'd4, 32'h0f0f_0f0f);
    rd(3'd4, "R8 mask value");
    wr(3'd3, 32'hffff_ffff);
    rd(3'd2, "R6 masked COR");
    rd(3'd0, "R5 mode");
    rd(3'd1, "R6 only returned bits cleared");

    // R9 collisions
    wr(3'd0, 32'h0000_0000);
    wr(3'd3, 32'h0000_0008);
    op(1'b1, 1'b0, 3'd1, 32'h0000_0008, 32'h0000_0008, "R9");
    rd(3'd1, "R9 event beats W1C");
    wr(3'd0, 32'h0000_0010);
    wr(3'd3, 32'h0000_0010);
    op(1'b0, 1'b1, 3'd1, '0, 32'h0000_0010, "R9 read");
    rd(3'd1, "R9 event beats COR");

    // R11 write-only and spare offsets read zero
    rd(3'd3, "R11 set reads 0");
    rd(3'd5, "R11 mset reads 0");
    rd(3'd6, "R11 mclr reads 0");
    rd(3'd7, "R11 spare reads 0");
    idleIrq("R10 final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule